// File: doc/BRIEF.md
# Load Issue Source Arbiter

This block sits at the entry of a load pipeline. In every cycle it looks at six request sources and picks one by a fixed ranking. It latches the chosen request into a single output register that feeds the first pipeline stage. Each source offers a valid/ready/payload handshake. A source that is not granted sees ready low and keeps its request unchanged until it wins.

Each issued flow carries its source number and a prefetch-kind tag. When the flow later completes, the pipeline returns the flow's tag, its kind and a translation-miss flag on a feedback port. The block then decides whether the flow must go back for another attempt.

- Hardware prefetches are never retried.
- Software prefetches are retried only when they miss the translation buffer. In that case they are handled like any load that missed.
- Ordinary loads that miss translation are always retried.

The block has two state machines. The output register moves between `OUT_EMPTY` and `OUT_FULL`:
- load: it goes to `OUT_FULL` when it accepts a grant.
- drain: it goes back to `OUT_EMPTY` when the downstream takes the flow and no grant arrives.
- hold: it stays in `OUT_FULL` while the downstream stalls.

The retry indicator moves between `RPL_IDLE` and `RPL_FIRE`:
- fire: it enters `RPL_FIRE` for one cycle on an eligible miss.
- settle: it returns to `RPL_IDLE` on the next cycle unless another eligible miss arrives.

Top module: `ld_issue_arbiter`

## Requirements
- R1: After reset, out_valid, replay_req and every req_ready bit are low.
- R2: Source index sets priority, and index 0 is the highest. The ranking is 0 = queue replay, 1 = confident hardware prefetch, 2 = scalar first issue (load or software prefetch), 3 = vector first issue, 4 = pointer-chase fast path, 5 = weak hardware prefetch.
- R3: At most one req_ready bit is high in a cycle. It goes to the lowest-indexed source whose valid is high, and only when the output can accept.
- R4: Source 4 gets ready only when sources 0, 2 and 3 all present no request in that cycle.
- R5: While out_valid is high and out_ready is low, no req_ready bit rises, and the output payload stays unchanged.
- R6: A flow granted in a cycle appears on the output after the next clock edge. out_src holds the 3-bit source index, and out_addr and out_tag hold the granted payload.
- R7: out_pfk encodes the prefetch kind as 2'b00 for none, 2'b01 for software and 2'b10 for hardware. Sources 1 and 5 carry hardware. Source 2 carries software when rs_swpf is high. Every other flow carries none.
- R8: A feedback beat with fb_tlb_miss high and fb_pfk not equal to 2'b10 raises replay_req on the next cycle for exactly one cycle, with replay_tag equal to fb_tag.
- R9: A feedback beat with fb_pfk = 2'b10, or with fb_tlb_miss low, leaves replay_req low on the next cycle.
- R10: When the output can accept and no source is valid, out_valid is low after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 6 | Request present, one bit per source |
| req_addr | input | 6 x ADDR_W | Address of each source's request |
| req_tag | input | 6 x TAG_W | Flow tag of each source's request |
| rs_swpf | input | 1 | Source 2 request is a software prefetch |
| req_ready | output | 6 | Grant, one bit per source |
| out_valid | output | 1 | Output register holds a flow |
| out_ready | input | 1 | Pipeline takes the output flow |
| out_addr | output | ADDR_W | Issued address |
| out_tag | output | TAG_W | Issued flow tag |
| out_src | output | 3 | Source index of the issued flow |
| out_pfk | output | 2 | Prefetch kind of the issued flow |
| fb_valid | input | 1 | Completion feedback present |
| fb_tlb_miss | input | 1 | The flow missed translation |
| fb_tag | input | TAG_W | Tag of the completing flow |
| fb_pfk | input | 2 | Prefetch kind of the completing flow |
| replay_req | output | 1 | One-cycle request to retry a flow |
| replay_tag | output | TAG_W | Tag of the flow to retry |

## Verification
Source selection and the retry decision can happen in the same cycle. The bench drives a completion beat with a translation miss in the same cycle that a new grant takes place. It then checks that the issued flow reaches the scoreboard intact and that the retry pulse shows up one cycle later with the right tag. An output stall can also overlap new arrivals from several sources. The bench holds out_ready low while higher-ranked requests appear, and it checks that no grant leaks out and that the held flow stays frozen. Once the stall lifts, the bench checks that the highest pending source wins.

// File: rtl/ld_issue_pkg.sv
package ld_issue_pkg;

    localparam int NSRC  = 6;
    localparam int SRC_W = 3;

    typedef enum logic [1:0] {
        PFK_NONE = 2'b00,
        PFK_SW   = 2'b01,
        PFK_HW   = 2'b10
    } pfk_e;

    typedef enum logic [2:0] {
        SRC_LSQ_REPLAY = 3'd0,
        SRC_HWPF_HI    = 3'd1,
        SRC_RS_SCALAR  = 3'd2,
        SRC_RS_VECTOR  = 3'd3,
        SRC_FASTPATH   = 3'd4,
        SRC_HWPF_LO    = 3'd5
    } src_e;

    typedef enum logic {
        OUT_EMPTY,
        OUT_FULL
    } out_state_e;

    typedef enum logic {
        RPL_IDLE,
        RPL_FIRE
    } rpl_state_e;

    // Prefetch kind attached to a flow at issue time.
    function automatic logic [1:0] kind_of(input logic [SRC_W-1:0] src, input logic swpf);
        logic [1:0] k;
        if (src == SRC_HWPF_HI || src == SRC_HWPF_LO)
            k = PFK_HW;
        else if (src == SRC_RS_SCALAR && swpf)
            k = PFK_SW;
        else
            k = PFK_NONE;
        return k;
    endfunction

endpackage

// File: rtl/ld_issue_prio.sv
module ld_issue_prio
    import ld_issue_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]     valid,
    input  logic             enable,
    output logic [N-1:0]     grant,
    output logic             any,
    output logic [SRC_W-1:0] idx
);

    // higher[i] is set when some source ranked above i is valid.
    logic [N:0] higher;

    assign higher[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign higher[i+1] = higher[i] | valid[i];
        assign grant[i]    = enable & valid[i] & ~higher[i];
    end

    assign any = enable & higher[N];

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (valid[i]) idx = SRC_W'(i);
        end
    end

endmodule

// File: rtl/ld_issue_outreg.sv
module ld_issue_outreg
    import ld_issue_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [SRC_W-1:0]  in_src,
    input  logic [1:0]        in_pfk,
    input  logic              out_ready,
    output logic              accept,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [TAG_W-1:0]  out_tag,
    output logic [SRC_W-1:0]  out_src,
    output logic [1:0]        out_pfk
);

    out_state_e state, nstate;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= OUT_EMPTY;
        else        state <= nstate;
    end

    always_comb begin
        accept = 1'b0;
        nstate = state;
        unique case (state)
            OUT_EMPTY: begin
                accept = 1'b1;
                if (load) nstate = OUT_FULL;            // load
            end
            OUT_FULL: begin
                accept = out_ready;
                if (out_ready && !load) nstate = OUT_EMPTY; // drain
                // otherwise hold (stall) or reload
            end
            default: nstate = OUT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr <= '0;
            out_tag  <= '0;
            out_src  <= '0;
            out_pfk  <= PFK_NONE;
        end else if (load) begin
            out_addr <= in_addr;
            out_tag  <= in_tag;
            out_src  <= in_src;
            out_pfk  <= in_pfk;
        end
    end

    assign out_valid = (state == OUT_FULL);

endmodule

// File: rtl/ld_issue_replay.sv
module ld_issue_replay
    import ld_issue_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fb_valid,
    input  logic             fb_tlb_miss,
    input  logic [TAG_W-1:0] fb_tag,
    input  logic [1:0]       fb_pfk,
    output logic             replay_req,
    output logic [TAG_W-1:0] replay_tag
);

    rpl_state_e state, nstate;
    logic       eligible;

    // Hardware prefetch never retries; software prefetch and loads retry on a miss.
    always_comb begin
        unique case (fb_pfk)
            PFK_HW:   eligible = 1'b0;
            PFK_SW:   eligible = fb_tlb_miss;
            PFK_NONE: eligible = fb_tlb_miss;
            default:  eligible = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RPL_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            RPL_IDLE: if (fb_valid && eligible) nstate = RPL_FIRE;   // fire
            RPL_FIRE: nstate = (fb_valid && eligible) ? RPL_FIRE : RPL_IDLE; // settle
            default:  nstate = RPL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                    replay_tag <= '0;
        else if (fb_valid && eligible) replay_tag <= fb_tag;
    end

    assign replay_req = (state == RPL_FIRE);

endmodule

// File: rtl/ld_issue_arbiter.sv
module ld_issue_arbiter
    import ld_issue_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC-1:0]              req_valid,
    input  logic [NSRC-1:0][ADDR_W-1:0]  req_addr,
    input  logic [NSRC-1:0][TAG_W-1:0]   req_tag,
    input  logic                         rs_swpf,
    output logic [NSRC-1:0]              req_ready,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [ADDR_W-1:0]            out_addr,
    output logic [TAG_W-1:0]             out_tag,
    output logic [SRC_W-1:0]             out_src,
    output logic [1:0]                   out_pfk,
    input  logic                         fb_valid,
    input  logic                         fb_tlb_miss,
    input  logic [TAG_W-1:0]             fb_tag,
    input  logic [1:0]                   fb_pfk,
    output logic                         replay_req,
    output logic [TAG_W-1:0]             replay_tag
);

    logic              accept;
    logic              any;
    logic [SRC_W-1:0]  sel;
    logic [NSRC-1:0]   gated_valid;
    logic              first_or_replay;

    // Fast path is opportunistic: masked whenever a replay or first issue waits.
    assign first_or_replay = req_valid[SRC_LSQ_REPLAY] | req_valid[SRC_RS_SCALAR]
                           | req_valid[SRC_RS_VECTOR];

    always_comb begin
        gated_valid = req_valid;
        gated_valid[SRC_FASTPATH] = req_valid[SRC_FASTPATH] & ~first_or_replay;
    end

    ld_issue_prio #(.N(NSRC)) u_prio (
        .valid  (gated_valid),
        .enable (accept),
        .grant  (req_ready),
        .any    (any),
        .idx    (sel)
    );

    ld_issue_outreg #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (any),
        .in_addr   (req_addr[sel]),
        .in_tag    (req_tag[sel]),
        .in_src    (sel),
        .in_pfk    (kind_of(sel, rs_swpf)),
        .out_ready (out_ready),
        .accept    (accept),
        .out_valid (out_valid),
        .out_addr  (out_addr),
        .out_tag   (out_tag),
        .out_src   (out_src),
        .out_pfk   (out_pfk)
    );

    ld_issue_replay #(.TAG_W(TAG_W)) u_rpl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fb_valid    (fb_valid),
        .fb_tlb_miss (fb_tlb_miss),
        .fb_tag      (fb_tag),
        .fb_pfk      (fb_pfk),
        .replay_req  (replay_req),
        .replay_tag  (replay_tag)
    );

endmodule

// File: rtl/ld_issue_arbiter_chk.sv
module ld_issue_arbiter_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        req_valid,
    input logic [5:0]        req_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic              fb_valid,
    input logic              fb_tlb_miss,
    input logic [1:0]        fb_pfk,
    input logic              replay_req
);

    a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    a_r3_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_ready & ~req_valid) == 6'b0));

    a_r4_fast_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready[4] |-> !(req_valid[0] || req_valid[2] || req_valid[3]));

    a_r5_no_grant_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> (req_ready == 6'b0));

    a_r5_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

    a_r8_replay_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_valid && fb_tlb_miss && fb_pfk != 2'b10) |=> replay_req);

    a_r9_hw_never: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_valid && fb_pfk == 2'b10) |=> !replay_req);

    a_r9_hit_never: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_valid && !fb_tlb_miss) |=> !replay_req);

endmodule

bind ld_issue_arbiter ld_issue_arbiter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_addr    (out_addr),
    .fb_valid    (fb_valid),
    .fb_tlb_miss (fb_tlb_miss),
    .fb_pfk      (fb_pfk),
    .replay_req  (replay_req)
);

// File: tb/ld_issue_arbiter_test.sv
`timescale 1ns/100ps
module ld_issue_arbiter_test;

    typedef struct packed {
        logic [2:0]  src;
        logic [31:0] addr;
        logic [5:0]  tag;
        logic [1:0]  pfk;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [5:0]        req_valid = '0;
    logic [5:0][31:0]  req_addr = '0;
    logic [5:0][5:0]   req_tag = '0;
    logic              rs_swpf = 1'b0;
    logic [5:0]        req_ready;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [31:0]       out_addr;
    logic [5:0]        out_tag;
    logic [2:0]        out_src;
    logic [1:0]        out_pfk;
    logic              fb_valid = 1'b0;
    logic              fb_tlb_miss = 1'b0;
    logic [5:0]        fb_tag = '0;
    logic [1:0]        fb_pfk = '0;
    logic              replay_req;
    logic [5:0]        replay_tag;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    item_t q[$];
    logic [5:0] pend = '0;
    logic [5:0] swpf_of = '0;

    always #2.5 clk = ~clk;

    ld_issue_arbiter uut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_kind(input int s, input logic sw);
        if (s == 1 || s == 5) return 2'b10;
        if (s == 2 && sw)     return 2'b01;
        return 2'b00;
    endfunction

    task automatic post(input int s, input logic [31:0] a, input logic [5:0] t, input logic sw);
        pend[s]     = 1'b1;
        req_addr[s] = a;
        req_tag[s]  = t;
        swpf_of[s]  = sw;
    endtask

    // Driver: one cycle of stimulus, predicts the grant and queues the expected flow.
    task automatic step(input logic ordy);
        logic [5:0] exp_rdy;
        int w;
        @(negedge clk);
        #1;
        out_ready = ordy;
        req_valid = pend;
        rs_swpf   = swpf_of[2];
        #0.2;
        exp_rdy = '0;
        w = -1;
        if (!out_valid || out_ready) begin
            for (int i = 5; i >= 0; i--) if (pend[i]) w = i;
        end
        if (w >= 0) exp_rdy[w] = 1'b1;
        check(req_ready == exp_rdy, "R3", "ready vector", req_ready, exp_rdy);
        if (w >= 0) begin
            q.push_back('{src: 3'(w), addr: req_addr[w], tag: req_tag[w],
                          pfk: exp_kind(w, swpf_of[w])});
            pend[w] = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard on each output handshake.
    always begin
        item_t e;
        @(negedge clk);
        #2;
        if (rst_n && out_valid && out_ready) begin
            if (q.size() == 0) begin
                check(0, "R6", "unexpected output", out_src, 0);
            end else begin
                e = q.pop_front();
                check(out_src == e.src, "R2", "source order", out_src, e.src);
                check(out_addr == e.addr && out_tag == e.tag, "R6", "payload",
                      {out_addr, out_tag}, {e.addr, e.tag});
                check(out_pfk == e.pfk, "R7", "prefetch kind", out_pfk, e.pfk);
            end
        end
    end

    task automatic feedback(input logic [5:0] t, input logic miss, input logic [1:0] k,
                            input bit expect_replay, input string req);
        @(negedge clk);
        #1;
        fb_valid = 1'b1; fb_tag = t; fb_tlb_miss = miss; fb_pfk = k;
        @(negedge clk);
        #1;
        fb_valid = 1'b0;
        #0.2;
        check(replay_req == expect_replay, req, "replay_req", replay_req, expect_replay);
        if (expect_replay) check(replay_tag == t, req, "replay_tag", replay_tag, t);
        @(negedge clk);
        #1.2;
        check(replay_req == 1'b0, "R8", "pulse width", replay_req, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        check(0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        #1.2;
        // R1 reset state
        check(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
        check(replay_req == 0, "R1", "replay_req in reset", replay_req, 0);
        check(req_ready == 0, "R1", "ready in reset", req_ready, 0);
        rst_n = 1'b1;

        // R2: all six at once drain in index order
        for (int s = 0; s < 6; s++) post(s, 32'h1000 + 32'(s) * 16, 6'(s + 1), 1'b0);
        repeat (7) step(1'b1);
        step(1'b1);
        check(out_valid == 0, "R10", "idle output", out_valid, 0);

        // R4: fast path wins only when replay/first issue idle
        post(4, 32'h2004, 6'h14, 0); post(5, 32'h2005, 6'h15, 0);
        repeat (3) step(1'b1);
        post(4, 32'h3004, 6'h24, 0); post(3, 32'h3003, 6'h23, 0);
        repeat (3) step(1'b1);
        post(4, 32'h3104, 6'h25, 0); post(0, 32'h3100, 6'h26, 0);
        repeat (3) step(1'b1);

        // R7: software prefetch on source 2
        post(2, 32'h4002, 6'h31, 1'b1);
        repeat (2) step(1'b1);
        swpf_of[2] = 1'b0;

        // R5: stall while higher sources arrive
        post(5, 32'h5005, 6'h35, 0);
        step(1'b1);
        post(2, 32'h5002, 6'h32, 0); post(1, 32'h5001, 6'h33, 0);
        step(1'b0);
        held = out_addr;
        step(1'b0);
        check(out_valid && out_addr == held, "R5", "held payload", out_addr, held);
        repeat (4) step(1'b1);
        check(out_valid == 0, "R10", "idle after drain", out_valid, 0);

        // R8 / R9 feedback decisions
        feedback(6'h0a, 1'b1, 2'b00, 1, "R8");
        feedback(6'h0b, 1'b1, 2'b01, 1, "R8");
        feedback(6'h0c, 1'b0, 2'b01, 0, "R9");
        feedback(6'h0d, 1'b1, 2'b10, 0, "R9");
        feedback(6'h0e, 1'b0, 2'b00, 0, "R9");

        // Grant and miss feedback in the same cycle
        post(3, 32'h6003, 6'h3e, 0);
        @(negedge clk); #1;
        fb_valid = 1'b1; fb_tag = 6'h2f; fb_tlb_miss = 1'b1; fb_pfk = 2'b00;
        req_valid = pend; out_ready = 1'b1;
        #0.2;
        check(req_ready == 6'b001000, "R3", "grant with feedback", req_ready, 6'b001000);
        q.push_back('{src: 3'd3, addr: 32'h6003, tag: 6'h3e, pfk: 2'b00});
        pend[3] = 1'b0;
        @(negedge clk); #1;
        fb_valid = 1'b0; req_valid = pend;
        #0.2;
        check(replay_req && replay_tag == 6'h2f, "R8", "concurrent replay",
              {replay_req, replay_tag}, {1'b1, 6'h2f});
        repeat (2) step(1'b1);
        check(q.size() == 0, "R6", "scoreboard drained", q.size(), 0);
        finish_run();
    end

endmodule